// File: doc/BRIEF.md
# SMI Trigger and Feature-Lock Controller

This block sits behind the power-management command port of a chipset. Every byte written to that port is decoded: two reserved values turn the ACPI enable state on or off, and any other value raises a system-management interrupt (SMI). The SMI goes out only if the command-trigger enable bit in the SMI enable register is set. It reaches either the CPU that issued the write or every CPU, depending on a broadcast feature bit.

The broadcast bit comes from a one-shot feature handshake. The host offers a fixed 64-bit feature map, and firmware writes a requested map byte by byte. Firmware then writes the acknowledge register. The request is copied into the negotiated map, and the acknowledge flag is set, only if every requested bit is also offered. Once the flag is set, the negotiated map cannot change until reset.

A separate sticky lock bit in a power-management control byte makes itself read-only once it is set. It also freezes bit 0 of the SMI enable register.

Top module: `smi_gate_ctrl`

## Requirements
- R1: After reset, `acpi_en` is 0 and `smi_pulse` is all zeros. The requested map, negotiated map, acknowledge flag, SMI enable byte and control byte all read 0.
- R2: A command write of `ACPI_ON_CMD` (default 8'hF0) sets `acpi_en` one cycle later, and a write of `ACPI_OFF_CMD` (default 8'hF1) clears it. Neither value produces any SMI pulse.
- R3: Any other command value pulses SMI one cycle after the write, but only when bit 5 of the SMI enable byte (address 5'h19) is 1. When that bit is 0, no pulse occurs. Without a command write, `smi_pulse` is all zeros.
- R4: When the negotiated map has bit 0 (broadcast) clear, only `smi_pulse[cmd_cpu]` is raised. Every pulse lasts exactly one cycle.
- R5: When negotiated bit 0 is 1, all bits of `smi_pulse` are raised together for one cycle.
- R6: A write to the acknowledge register (address 5'h18, any data) is rejected if the requested map holds any bit outside the offered map. A rejected write leaves the acknowledge flag at 0 and the negotiated map at 0.
- R7: An acknowledge write whose request is a subset of the offered map copies the request into the negotiated map and sets the acknowledge flag. The flag reads as 8'h01 at address 5'h18.
- R8: Once the acknowledge flag is 1, further acknowledge writes change neither the flag nor the negotiated map, even if the request has changed.
- R9: Bit 4 of the control byte (address 5'h1A) is the lock. Once it is 1, it stays 1 until reset, and bit 0 of the SMI enable byte keeps its value. All other bits of both bytes stay writable.
- R10: The offered map reads at addresses 5'h08 to 5'h0F, least significant byte first, and ignores writes. By default it holds only bit 0 (broadcast).
- R11: A reset in mid-operation clears the requested map, negotiated map, acknowledge flag and lock, and leaves the offered map unchanged.
- R12: The requested map is written and read as little-endian bytes at addresses 5'h00 to 5'h07, and the negotiated map reads the same way at 5'h10 to 5'h17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command port write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_cpu | input | CPU_W | Index of the CPU issuing the command |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| acpi_en | output | 1 | ACPI enable state |
| smi_pulse | output | NUM_CPU | Per-CPU SMI pulses |

## Verification
The command port is tried with both ACPI codes and with ordinary codes. Ordinary codes are sent with the trigger enable off and on, and from different requesting CPUs. This separates command decode from enable gating and from the choice of target CPU.

Negotiation is tried with a request that has a bit outside the offer in the low byte, one with such a bit in the top byte, a valid subset, and a changed request after the lock. Together these show the subset check covers all eight bytes and that the lock holds.

SMIs are sent before and after broadcast is negotiated, which separates single-target delivery from broadcast. Lock tests write to both locked and unlocked bits, so a frozen bit is told apart from a frozen byte.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int FEAT_W     = 64;
    localparam int BYTE_W     = 8;
    localparam int FEAT_BYTES = FEAT_W / BYTE_W;
    localparam int ADDR_W     = 5;

    localparam logic [ADDR_W-1:0] A_ACK    = 5'h18;
    localparam logic [ADDR_W-1:0] A_SMI_EN = 5'h19;
    localparam logic [ADDR_W-1:0] A_PMCTL  = 5'h1A;

    localparam logic [1:0] BANK_REQ   = 2'b00;
    localparam logic [1:0] BANK_OFFER = 2'b01;
    localparam logic [1:0] BANK_NEG   = 2'b10;

    localparam int TRIG_EN_BIT = 5;
    localparam int LOCK_BIT    = 4;
    localparam int BCAST_BIT   = 0;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_ACPI_ON,
        CK_ACPI_OFF,
        CK_SMI
    } cmd_kind_e;

    function automatic cmd_kind_e classify_cmd(input logic we, input logic [7:0] d,
                                               input logic [7:0] on_code,
                                               input logic [7:0] off_code);
        if (!we)                return CK_NONE;
        else if (d == on_code)  return CK_ACPI_ON;
        else if (d == off_code) return CK_ACPI_OFF;
        else                    return CK_SMI;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [FEAT_W-1:0] v,
                                                    input logic [2:0] idx);
        return v[idx*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/smi_feat_neg.sv
module smi_feat_neg
    import smi_pkg::*;
#(
    parameter logic [FEAT_W-1:0] HOST_FEATS = 64'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [FEAT_W-1:0] req_q,
    output logic [FEAT_W-1:0] neg_q,
    output logic              ok_q
);
    logic subset_ok;
    assign subset_ok = ((req_q & ~HOST_FEATS) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            neg_q <= '0;
            ok_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr[4:3] == BANK_REQ)
                req_q[wr_addr[2:0]*BYTE_W +: BYTE_W] <= wr_data;
            if (wr_addr == A_ACK && !ok_q && subset_ok) begin
                neg_q <= req_q;
                ok_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/smi_ctl_regs.sv
module smi_ctl_regs
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] smi_en_q,
    output logic [BYTE_W-1:0] pmctl_q
);
    localparam logic [BYTE_W-1:0] LOCK_MASK = BYTE_W'(1) << LOCK_BIT;
    logic locked;
    assign locked = pmctl_q[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_en_q <= '0;
            pmctl_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_SMI_EN)
                smi_en_q <= locked ? {wr_data[BYTE_W-1:1], smi_en_q[0]} : wr_data;
            if (wr_addr == A_PMCTL)
                pmctl_q <= locked ? (wr_data | LOCK_MASK) : wr_data;
        end
    end
endmodule

// File: rtl/smi_cmd_dec.sv
module smi_cmd_dec
    import smi_pkg::*;
#(
    parameter int          NUM_CPU      = 4,
    parameter int          CPU_W        = 2,
    parameter logic [7:0]  ACPI_ON_CMD  = 8'hF0,
    parameter logic [7:0]  ACPI_OFF_CMD = 8'hF1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_we,
    input  logic [7:0]         cmd_data,
    input  logic [CPU_W-1:0]   cmd_cpu,
    input  logic               trig_en,
    input  logic               bcast,
    output logic               acpi_q,
    output logic [NUM_CPU-1:0] smi_q
);
    cmd_kind_e          kind;
    logic               fire;
    logic [NUM_CPU-1:0] target;

    assign kind = classify_cmd(cmd_we, cmd_data, ACPI_ON_CMD, ACPI_OFF_CMD);
    assign fire = (kind == CK_SMI) && trig_en;

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_tgt
        assign target[i] = fire && (bcast || (cmd_cpu == CPU_W'(i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acpi_q <= 1'b0;
            smi_q  <= '0;
        end else begin
            smi_q <= target;
            if (kind == CK_ACPI_ON)       acpi_q <= 1'b1;
            else if (kind == CK_ACPI_OFF) acpi_q <= 1'b0;
        end
    end
endmodule

// File: rtl/smi_gate_ctrl.sv
module smi_gate_ctrl
    import smi_pkg::*;
#(
    parameter int                NUM_CPU      = 4,
    parameter int                CPU_W        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    parameter logic [7:0]        ACPI_ON_CMD  = 8'hF0,
    parameter logic [7:0]        ACPI_OFF_CMD = 8'hF1,
    parameter logic [FEAT_W-1:0] HOST_FEATS   = 64'h1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_we,
    input  logic [7:0]         cmd_data,
    input  logic [CPU_W-1:0]   cmd_cpu,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    output logic               acpi_en,
    output logic [NUM_CPU-1:0] smi_pulse
);
    logic [FEAT_W-1:0] req_q, neg_q;
    logic              ok_q;
    logic [BYTE_W-1:0] smi_en_q, pmctl_q;

    smi_feat_neg #(.HOST_FEATS(HOST_FEATS)) u_neg (
        .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .req_q(req_q), .neg_q(neg_q), .ok_q(ok_q)
    );

    smi_ctl_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .smi_en_q(smi_en_q), .pmctl_q(pmctl_q)
    );

    smi_cmd_dec #(
        .NUM_CPU(NUM_CPU), .CPU_W(CPU_W),
        .ACPI_ON_CMD(ACPI_ON_CMD), .ACPI_OFF_CMD(ACPI_OFF_CMD)
    ) u_dec (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .cmd_cpu(cmd_cpu), .trig_en(smi_en_q[TRIG_EN_BIT]),
        .bcast(neg_q[BCAST_BIT]), .acpi_q(acpi_en), .smi_q(smi_pulse)
    );

    always_comb begin
        unique case (reg_addr[4:3])
            BANK_REQ:   reg_rdata = pick_byte(req_q, reg_addr[2:0]);
            BANK_OFFER: reg_rdata = pick_byte(HOST_FEATS, reg_addr[2:0]);
            BANK_NEG:   reg_rdata = pick_byte(neg_q, reg_addr[2:0]);
            default: begin
                if (reg_addr == A_ACK)         reg_rdata = {{(BYTE_W-1){1'b0}}, ok_q};
                else if (reg_addr == A_SMI_EN) reg_rdata = smi_en_q;
                else if (reg_addr == A_PMCTL)  reg_rdata = pmctl_q;
                else                           reg_rdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/smi_gate_chk.sv
module smi_gate_chk
    import smi_pkg::*;
#(
    parameter int         NUM_CPU      = 4,
    parameter int         CPU_W        = 2,
    parameter logic [7:0] ACPI_ON_CMD  = 8'hF0,
    parameter logic [7:0] ACPI_OFF_CMD = 8'hF1,
    parameter logic [FEAT_W-1:0] HOST_FEATS = 64'h1
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_we,
    input logic [7:0]         cmd_data,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               acpi_en,
    input logic [NUM_CPU-1:0] smi_pulse,
    input logic [FEAT_W-1:0]  req_q,
    input logic [FEAT_W-1:0]  neg_q,
    input logic               ok_q,
    input logic [BYTE_W-1:0]  smi_en_q,
    input logic [BYTE_W-1:0]  pmctl_q
);
    logic is_acpi_cmd;
    assign is_acpi_cmd = cmd_we && (cmd_data == ACPI_ON_CMD || cmd_data == ACPI_OFF_CMD);

    // R2
    acpi_on_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_data == ACPI_ON_CMD |=> acpi_en);
    // R2
    acpi_no_smi_chk: assert property (@(posedge clk) disable iff (rst)
        is_acpi_cmd |=> smi_pulse == '0);
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> smi_pulse == '0);
    // R4
    single_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && !neg_q[BCAST_BIT] |=> $onehot0(smi_pulse));
    // R5
    bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && !is_acpi_cmd && smi_en_q[TRIG_EN_BIT] && neg_q[BCAST_BIT]
        |=> smi_pulse == {NUM_CPU{1'b1}});
    // R6
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we && reg_addr == A_ACK && !ok_q && ((req_q & ~HOST_FEATS) != '0) |=> !ok_q);
    // R8
    ack_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ok_q |=> ok_q && $stable(neg_q));
    // R9
    pm_lock_chk: assert property (@(posedge clk) disable iff (rst)
        pmctl_q[LOCK_BIT] |=> pmctl_q[LOCK_BIT] && $stable(smi_en_q[0]));
endmodule

bind smi_gate_ctrl smi_gate_chk #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ACPI_ON_CMD(ACPI_ON_CMD),
    .ACPI_OFF_CMD(ACPI_OFF_CMD), .HOST_FEATS(HOST_FEATS)
) u_chk (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .acpi_en(acpi_en),
    .smi_pulse(smi_pulse), .req_q(req_q), .neg_q(neg_q), .ok_q(ok_q),
    .smi_en_q(smi_en_q), .pmctl_q(pmctl_q)
);

// File: tb/smi_gate_ctrl_tb.sv
module smi_gate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic [1:0] cmd_cpu = 2'd0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = 5'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       acpi_en;
    logic [3:0] smi_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    smi_gate_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .cmd_cpu(cmd_cpu), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acpi_en(acpi_en), .smi_pulse(smi_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // send a command; pulse checked in the cycle after the write, then zero
    task automatic cmd(input logic [7:0] d, input logic [1:0] cpu,
                       input logic [3:0] exp_pulse, input string req);
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = d; cmd_cpu = cpu;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(smi_pulse == exp_pulse, req, smi_pulse, exp_pulse);
        @(negedge clk);
        chk(smi_pulse == 4'b0000, "R4 one-cycle pulse", smi_pulse, 0);
    endtask

    task automatic t_reset_state();
        chk(acpi_en == 1'b0, "R1 acpi_en", acpi_en, 0);
        chk(smi_pulse == 4'b0, "R1 smi_pulse", smi_pulse, 0);
        for (int i = 0; i < 8; i++) begin
            rd_chk(5'(i), 8'h00, "R1 requested");
            rd_chk(5'h10 + 5'(i), 8'h00, "R1 negotiated");
            rd_chk(5'h08 + 5'(i), (i == 0) ? 8'h01 : 8'h00, "R10 offered default");
        end
        rd_chk(5'h18, 8'h00, "R1 ack");
        rd_chk(5'h19, 8'h00, "R1 smi_en");
        rd_chk(5'h1A, 8'h00, "R1 pmctl");
    endtask

    task automatic t_acpi();
        cmd(8'hF0, 2'd1, 4'b0000, "R2 on no smi");
        chk(acpi_en == 1'b1, "R2 acpi on", acpi_en, 1);
        wr(5'h19, 8'h20);
        cmd(8'hF1, 2'd1, 4'b0000, "R2 off no smi with trigger enabled");
        chk(acpi_en == 1'b0, "R2 acpi off", acpi_en, 0);
        wr(5'h19, 8'h00);
    endtask

    task automatic t_single();
        cmd(8'h42, 2'd2, 4'b0000, "R3 trigger disabled");
        wr(5'h19, 8'h20);
        cmd(8'h42, 2'd2, 4'b0100, "R3 R4 cpu2");
        cmd(8'h07, 2'd0, 4'b0001, "R4 cpu0");
        cmd(8'hFF, 2'd3, 4'b1000, "R4 cpu3");
        chk(acpi_en == 1'b0, "R2 smi cmd leaves acpi", acpi_en, 0);
    endtask

    task automatic t_reject();
        wr(5'h00, 8'h03);
        wr(5'h18, 8'h01);
        rd_chk(5'h18, 8'h00, "R6 low-byte reject ack");
        rd_chk(5'h10, 8'h00, "R6 low-byte reject neg");
        wr(5'h00, 8'h01);
        wr(5'h07, 8'h80);
        rd_chk(5'h07, 8'h80, "R12 requested byte7");
        wr(5'h18, 8'h01);
        rd_chk(5'h18, 8'h00, "R6 high-byte reject ack");
        rd_chk(5'h10, 8'h00, "R6 high-byte reject neg");
        cmd(8'h42, 2'd1, 4'b0010, "R6 still single target");
    endtask

    task automatic t_accept();
        wr(5'h07, 8'h00);
        wr(5'h18, 8'h00);
        rd_chk(5'h18, 8'h01, "R7 ack set");
        rd_chk(5'h10, 8'h01, "R7 R12 neg byte0");
        rd_chk(5'h17, 8'h00, "R12 neg byte7");
        cmd(8'h42, 2'd1, 4'b1111, "R5 broadcast");
        wr(5'h00, 8'h00);
        wr(5'h18, 8'h00);
        rd_chk(5'h18, 8'h01, "R8 ack stays");
        rd_chk(5'h10, 8'h01, "R8 neg stays");
        cmd(8'h55, 2'd0, 4'b1111, "R8 R5 still broadcast");
        wr(5'h08, 8'hAA);
        rd_chk(5'h08, 8'h01, "R10 offered write ignored");
    endtask

    task automatic t_lock();
        wr(5'h19, 8'h21);
        rd_chk(5'h19, 8'h21, "R9 smi_en before lock");
        wr(5'h1A, 8'h10);
        rd_chk(5'h1A, 8'h10, "R9 lock set");
        wr(5'h1A, 8'h03);
        rd_chk(5'h1A, 8'h13, "R9 lock sticky other bits writable");
        wr(5'h19, 8'h00);
        rd_chk(5'h19, 8'h01, "R9 bit0 frozen others written");
        wr(5'h19, 8'h20);
        rd_chk(5'h19, 8'h21, "R9 bit0 still frozen");
    endtask

    task automatic t_midreset();
        wr(5'h03, 8'h5A);
        do_reset();
        rd_chk(5'h18, 8'h00, "R11 ack cleared");
        rd_chk(5'h10, 8'h00, "R11 neg cleared");
        rd_chk(5'h03, 8'h00, "R11 req cleared");
        rd_chk(5'h1A, 8'h00, "R11 lock cleared");
        rd_chk(5'h08, 8'h01, "R11 offered kept");
        wr(5'h19, 8'h20);
        cmd(8'h42, 2'd3, 4'b1000, "R11 broadcast gone");
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_acpi();
        t_single();
        t_reject();
        t_accept();
        t_lock();
        t_midreset();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule